// File: doc/BRIEF.md
# Frame-Synchronized Serial Codec Port

This block is a full-duplex serial port that sits between a processor and an audio-style codec. It has a transmit section and a receive section. Each section has its own bit clock, frame sync and serial data line. A one-cycle frame-sync pulse, seen on a rising bit-clock edge, opens a word. The word then moves one bit per following rising edge, most significant bit first. For each section an idle flag sits high when no word is in flight, drops for the length of a word, and rises again once the final bit has moved. Both sections work when their clocks and syncs are tied to one shared codec clock and sync.

The bit clocks, syncs and serial input are treated as slow signals. They are resynchronized into the fast system clock, and each section acts on the rising edges it detects there. On the parallel side, the words to send enter through a valid/ready stream into a single holding slot. A frame sync takes the word out of the slot. `tx_ready` is high only while the slot is empty, and a word is accepted on a system clock edge where `tx_valid` and `tx_ready` are both high. Received words leave through a valid/ready stream as well. `rx_valid` and `rx_data` stay put until `rx_ready` takes the word. The link cannot be stalled, so a new word that arrives before the held one is taken replaces it, and this is flagged. A sync that finds the transmit slot empty sends zeros and is flagged.

Top module: `ssp_codec_port`

## Requirements
- R1: After reset `xmit_idle` and `recv_idle` are 1, `dx` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: When `fsx` is high at a rising edge of `clkx` while transmit is idle, a word starts and `xmit_idle` goes to 0. After that edge `dx` carries bit W-1 of the word. Each later rising edge of `clkx` moves `dx` to the next lower bit, so bits go out most significant first.
- R3: When `fsr` is high at a rising edge of `clkr` while receive is idle, a word starts. `dr` is sampled on each of the next W rising edges of `clkr`. The first sample becomes bit W-1 of `rx_data`.
- R4: Each idle flag stays 0 while its word is in flight and returns to 1 at the W-th rising edge after the sync edge (default W = 8).
- R5: The transmit slot holds one word: `tx_ready` is 0 from acceptance until a frame sync takes the word, then returns to 1.
- R6: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` does not change until another word completes.
- R7: If transmit has no word in its slot when a sync starts a word, `dx` sends all zeros for that word and `tx_underrun` pulses for one system clock.
- R8: If a received word completes while the previous one is still unread, the new word replaces it in `rx_data` and `rx_overrun` pulses for one system clock.
- R9: A frame sync seen while a word is still in progress (before its final edge) has no effect. The word completes unchanged and no extra word follows.
- R10: The sections are independent: clocking only the transmit side leaves `recv_idle` at 1 and `rx_valid` at 0, and clocking only the receive side leaves `xmit_idle` at 1, `dx` at 0 and no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| clkx | input | 1 | Transmit bit clock |
| fsx | input | 1 | Transmit frame sync |
| dx | output | 1 | Serial data to codec |
| clkr | input | 1 | Receive bit clock |
| fsr | input | 1 | Receive frame sync |
| dr | input | 1 | Serial data from codec |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit slot empty |
| tx_data | input | WORD_BITS | Word to send |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes received word |
| rx_data | output | WORD_BITS | Received word |
| xmit_idle | output | 1 | High when no transmit word in flight |
| recv_idle | output | 1 | High when no receive word in flight |
| tx_underrun | output | 1 | One-cycle pulse: word started with empty slot |
| rx_overrun | output | 1 | One-cycle pulse: unread word replaced |

## Verification
A table of word pairs runs with the clocks and syncs tied. Each row sends one word and receives a different one at the same time. The rows include alternating bits, single set bits at either end, all ones and all zeros, so an LSB-first order, a shifted alignment or crossed data paths would each give a wrong word. Separate runs then use these patterns:
- a frame with an empty slot, which separates the zero-fill and underrun path from normal sending;
- two unread frames, which separate replacement from keeping the old word;
- an extra sync in mid-word, which shows that it is ignored rather than restarting the word;
- clocking only one section, which shows that transmit and receive do not share state.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  localparam int DEF_WORD_BITS   = 8;
  localparam int DEF_SYNC_STAGES = 2;

  // One serial lane after resynchronization: a rising-edge strobe of the
  // bit clock plus the sync and data levels aligned with it.
  typedef struct packed {
    logic tick;
    logic fs;
    logic dat;
  } lane_t;
endpackage

// File: rtl/ssp_lane_sync.sv
`timescale 1ns/1ps
module ssp_lane_sync
  import ssp_pkg::*;
#(
  parameter int STAGES = DEF_SYNC_STAGES
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bclk,
  input  logic  fs,
  input  logic  dat,
  output lane_t lane
);
  localparam int LAST = STAGES - 1;

  logic [2:0] pipe [STAGES];
  logic       prev_ck;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= {bclk, fs, dat};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ck <= 1'b0;
    else        prev_ck <= pipe[LAST][2];
  end

  always_comb begin
    lane.tick = pipe[LAST][2] & ~prev_ck;
    lane.fs   = pipe[LAST][1];
    lane.dat  = pipe[LAST][0];
  end
endmodule

// File: rtl/ssp_tx.sv
`timescale 1ns/1ps
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int W = DEF_WORD_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  lane_t        lane,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         dx,
  output logic         idle,
  output logic         underrun
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  hold;
  logic          hold_full;
  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          busy;
  logic          last;
  logic          start;

  assign last    = busy && (cnt == '0);
  assign start   = lane.tick && lane.fs && (!busy || last);
  assign s_ready = !hold_full;
  assign dx      = shreg[W-1];
  assign idle    = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(W - 1);
        if (hold_full) begin
          shreg <= hold;
        end else begin
          shreg    <= '0;
          underrun <= 1'b1;
        end
      end else if (lane.tick && busy) begin
        if (last) begin
          busy  <= 1'b0;
          shreg <= '0;
        end else begin
          shreg <= {shreg[W-2:0], 1'b0};
          cnt   <= cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else begin
      if (start && hold_full) hold_full <= 1'b0;
      if (s_valid && s_ready) begin
        hold      <= s_data;
        hold_full <= 1'b1;
      end
    end
  end

  // R1: no word in flight means the line rests low
  p_idle_dx_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dx);
  // R2: a sync on an idle section opens a word
  p_sync_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane.tick && lane.fs && !busy) |=> !idle);
  // R5: an accepted word closes the slot
  p_slot_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
  // R7: an underrun word carries zeros
  p_underrun_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (shreg == '0) && busy);
  // R9: a word that is not at its last bit keeps going
  p_midword_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: rtl/ssp_rx.sv
`timescale 1ns/1ps
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int W = DEF_WORD_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  lane_t        lane,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  output logic         idle,
  output logic         overrun
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-2:0]  shreg;
  logic [W-1:0]  assembled;
  logic [CW-1:0] cnt;
  logic          busy;
  logic          last;
  logic          start;
  logic          finish;

  assign last      = busy && (cnt == '0);
  assign start     = lane.tick && lane.fs && (!busy || last);
  assign finish    = lane.tick && last;
  assign assembled = {shreg, lane.dat};
  assign idle      = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (lane.tick && busy) begin
        shreg <= assembled[W-2:0];
        if (last) begin
          busy    <= 1'b0;
          m_data  <= assembled;
          m_valid <= 1'b1;
          overrun <= m_valid && !m_ready;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(W - 1);
      end
    end
  end

  // R3: a sync on an idle receiver opens a word
  p_sync_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane.tick && lane.fs && !busy) |=> !idle);
  // R6: an unread word is held steady
  p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !finish) |=> m_valid && $stable(m_data));
  // R8: an overrun leaves a fresh word on offer
  p_overrun_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> m_valid);
  // R9: mid-word syncs do not end the word early
  p_midword_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: rtl/ssp_codec_port.sv
`timescale 1ns/1ps
module ssp_codec_port
  import ssp_pkg::*;
#(
  parameter int WORD_BITS   = DEF_WORD_BITS,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clkx,
  input  logic                 fsx,
  output logic                 dx,
  input  logic                 clkr,
  input  logic                 fsr,
  input  logic                 dr,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [WORD_BITS-1:0] tx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [WORD_BITS-1:0] rx_data,
  output logic                 xmit_idle,
  output logic                 recv_idle,
  output logic                 tx_underrun,
  output logic                 rx_overrun
);
  lane_t x_lane;
  lane_t r_lane;

  // The transmit lane carries no serial input; tie its data slot low.
  ssp_lane_sync #(.STAGES(SYNC_STAGES)) u_xsync (
    .clk(clk), .rst_n(rst_n), .bclk(clkx), .fs(fsx), .dat(1'b0), .lane(x_lane)
  );

  ssp_lane_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .bclk(clkr), .fs(fsr), .dat(dr), .lane(r_lane)
  );

  ssp_tx #(.W(WORD_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .lane(x_lane),
    .s_valid(tx_valid), .s_ready(tx_ready), .s_data(tx_data),
    .dx(dx), .idle(xmit_idle), .underrun(tx_underrun)
  );

  ssp_rx #(.W(WORD_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .lane(r_lane),
    .m_valid(rx_valid), .m_ready(rx_ready), .m_data(rx_data),
    .idle(recv_idle), .overrun(rx_overrun)
  );

  // R10: receive activity never wakes the transmitter
  p_tx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_idle && !x_lane.tick) |=> xmit_idle);
endmodule

// File: tb/ssp_codec_port_bench.sv
`timescale 1ns/1ps
module ssp_codec_port_bench;
  localparam int W    = 8;
  localparam int HALF = 6;
  localparam int NV   = 6;
  // each row: {word to send, word the codec returns}
  localparam logic [15:0] VEC [NV] = '{
    16'hA5_3C, 16'h80_01, 16'h01_80, 16'hFF_00, 16'h00_FF, 16'h5A_C3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clkx = 0, fsx = 0, clkr = 0, fsr = 0, dr = 0;
  logic tx_valid = 0, rx_ready = 0;
  logic [W-1:0] tx_data = '0;
  logic dx, tx_ready, rx_valid, xmit_idle, recv_idle, tx_underrun, rx_overrun;
  logic [W-1:0] rx_data;

  int total = 0;
  int bad = 0;
  int und_cnt = 0;
  int ovr_cnt = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  ssp_codec_port #(.WORD_BITS(W)) u_ssp_codec_port (
    .clk(clk), .rst_n(rst_n), .clkx(clkx), .fsx(fsx), .dx(dx),
    .clkr(clkr), .fsr(fsr), .dr(dr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .xmit_idle(xmit_idle), .recv_idle(recv_idle),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
  );

  always @(negedge clk) begin
    if (tx_underrun) und_cnt++;
    if (rx_overrun)  ovr_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = w;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  // One frame: edge 0 carries the sync, edges 1..W carry the bits.
  task automatic frame(input logic do_tx, input logic do_rx, input logic [W-1:0] rxw,
                       input int extra_sync, output logic [W-1:0] got,
                       output logic busy_ok, output logic other_idle);
    got = '0;
    busy_ok = 1'b1;
    other_idle = 1'b1;
    for (int j = 0; j <= W + 2; j++) begin
      @(negedge clk);
      if (do_tx) fsx = (j == 0) || (j == extra_sync);
      if (do_rx) begin
        fsr = (j == 0) || (j == extra_sync);
        dr  = (j >= 1 && j <= W) ? rxw[W-j] : 1'b0;
      end
      repeat (HALF) @(negedge clk);
      if (j >= 1 && j <= W) begin
        got = {got[W-2:0], dx};
        if (do_tx && xmit_idle) busy_ok = 1'b0;
        if (do_rx && recv_idle) busy_ok = 1'b0;
      end
      if (!do_rx && !recv_idle) other_idle = 1'b0;
      if (!do_tx && !xmit_idle) other_idle = 1'b0;
      if (do_tx) clkx = 1'b1;
      if (do_rx) clkr = 1'b1;
      repeat (HALF) @(negedge clk);
      clkx = 1'b0;
      clkr = 1'b0;
    end
    fsx = 1'b0;
    fsr = 1'b0;
    dr  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    logic busy_ok, other_idle;
    int u0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 xmit_idle", xmit_idle, 1);
    chk("R1 recv_idle", recv_idle, 1);
    chk("R1 dx", dx, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk with tied clocks and syncs
    for (int v = 0; v < NV; v++) begin
      push(VEC[v][15:8]);
      chk("R5 slot full", tx_ready, 0);
      frame(1'b1, 1'b1, VEC[v][7:0], -1, got, busy_ok, other_idle);
      chk("R2 dx word", got, VEC[v][15:8]);
      chk("R4 flags low in word", busy_ok, 1);
      chk("R4 flags high after", {xmit_idle, recv_idle}, 2'b11);
      chk("R3 rx word", rx_data, VEC[v][7:0]);
      chk("R3 rx valid", rx_valid, 1);
      chk("R5 slot freed", tx_ready, 1);
      take();
    end
    chk("R7 no underrun in table", und_cnt, 0);
    chk("R8 no overrun in table", ovr_cnt, 0);

    // R7: empty slot sends zeros
    frame(1'b1, 1'b1, 8'h96, -1, got, busy_ok, other_idle);
    chk("R7 zero word", got, 0);
    chk("R7 underrun pulse", und_cnt, 1);
    take();

    // R6 / R8: unread word held, then replaced
    push(8'h11);
    frame(1'b1, 1'b1, 8'h3E, -1, got, busy_ok, other_idle);
    repeat (20) @(negedge clk);
    chk("R6 held valid", rx_valid, 1);
    chk("R6 held data", rx_data, 8'h3E);
    push(8'h22);
    frame(1'b1, 1'b1, 8'hC1, -1, got, busy_ok, other_idle);
    chk("R8 overrun pulse", ovr_cnt, 1);
    chk("R8 newest word", rx_data, 8'hC1);
    take();
    @(negedge clk);
    chk("R6 consumed", rx_valid, 0);

    // R9: sync in mid-word is ignored
    push(8'hB4);
    u0 = und_cnt;
    frame(1'b1, 1'b1, 8'h6D, 4, got, busy_ok, other_idle);
    chk("R9 dx word", got, 8'hB4);
    chk("R9 rx word", rx_data, 8'h6D);
    chk("R9 no restart", {xmit_idle, recv_idle}, 2'b11);
    chk("R9 no extra tx word", und_cnt, u0);
    take();
    @(negedge clk);
    chk("R9 no extra rx word", rx_valid, 0);

    // R10: transmit-only, then receive-only
    push(8'h47);
    frame(1'b1, 1'b0, 8'h00, -1, got, busy_ok, other_idle);
    chk("R10 tx alone word", got, 8'h47);
    chk("R10 receiver quiet", other_idle, 1);
    chk("R10 no rx word", rx_valid, 0);
    u0 = und_cnt;
    frame(1'b0, 1'b1, 8'hE2, -1, got, busy_ok, other_idle);
    chk("R10 rx alone word", rx_data, 8'hE2);
    chk("R10 transmitter quiet", other_idle, 1);
    chk("R10 dx stays low", got, 0);
    chk("R10 no underrun", und_cnt, u0);
    take();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule